// File: doc/BRIEF.md
# Performance State Transition Sequencer

This block moves a processor's shared operating point from one performance state to another. Software writes a 16-bit control word that names a target state. The block works out the matching supply voltage code and the clock-generator ratio for that state by itself. It then drives a regulator request and a PLL ratio request, one at a time. The order of the two steps depends on whether the change raises or lowers performance, so the clock never runs faster than the supply can support. State 0 is the fastest and highest-voltage point, and each larger index is slower. A single operating point covers every core, so there is no per-core setting.

A separate 16-bit status word reports the operating point that has actually been reached. It changes only when the last step of a transition has been acknowledged. Requests are taken only while the core reports itself active. A request written during a transition waits in a one-deep slot, and a newer write replaces an older one that has not started yet.

Top module: `perf_state_sequencer`

## Requirements
- R1: After reset the committed state is NUM_PS-1 (7 by default). The status word reads {ratio 14, state 7}, the voltage output is 140, the ratio output is 14, both request outputs are low and the control readback is 0.
- R2: A control write takes effect only when `core_active` is high in the same cycle. It then stores all 16 bits for readback and queues a transition. A write while `core_active` is low changes neither the readback nor the operating point.
- R3: The target state is taken from control bits [7:0]. A value of NUM_PS or more is treated as state NUM_PS-1.
- R4: For state p, the ratio is 35-3p and the voltage code is the larger of 200-10p and 140.
- R5: On a move to a lower index (higher performance), the voltage request goes out first with the target code. The PLL request with the target ratio rises only after the regulator acknowledges, and the two requests are never high together.
- R6: On a move to a higher index (lower performance), the PLL request with the target ratio goes out first. The voltage request rises only after PLL lock.
- R7: The status word is {ratio of committed state in [15:8], committed state in [7:0]}. It changes only in the cycle after the final acknowledge or lock of a transition.
- R8: A write made while a transition is running is held and started once the transition finishes. Only the most recent such write is kept.
- R9: A request for the state already committed produces no regulator or PLL request.
- R10: A request output stays high with its value unchanged until the matching acknowledge or lock is sampled. It then drops on the next edge. The first request of a transition rises two clock edges after the accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_active | input | 1 | High while the core is in its active state |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 16 | Control word; bits [7:0] name the target state |
| ctrl_rdata | output | 16 | Last accepted control word |
| stat_rdata | output | 16 | Committed operating point {ratio, state} |
| vr_req | output | 1 | Voltage regulator request |
| vr_vid | output | VID_W | Requested voltage code |
| vr_ack | input | 1 | Regulator acknowledge, one cycle |
| pll_req | output | 1 | PLL ratio request |
| pll_ratio | output | RATIO_W | Requested PLL ratio |
| pll_lock | input | 1 | PLL lock indication, one cycle |

## Verification
The bench targets the step order in both directions. A design with the order swapped would raise the PLL ratio before the supply has been acknowledged, or lower the voltage while the clock is still fast. Writes made during a long transition are also exercised. A design that dropped the held request would stop at the intermediate state, and one that kept the older request would make an extra transition. The bench further covers out-of-range state fields, requests for the point already committed, and writes while the core is idle. Faults there show up as a wrong final point, a needless handshake, or a changed readback. The per-cycle reference also catches a status word that moves early, before the final lock or acknowledge.

// File: rtl/psq_pkg.sv
package psq_pkg;

   localparam int CSR_W = 16;

   typedef enum logic [2:0] {
      SQ_IDLE     = 3'd0,
      SQ_V_FIRST  = 3'd1,
      SQ_F_SECOND = 3'd2,
      SQ_F_FIRST  = 3'd3,
      SQ_V_SECOND = 3'd4
   } sq_state_e;

   function automatic int psq_ratio_of(int p, int top, int step);
      return top - p * step;
   endfunction

   function automatic int psq_vid_of(int p, int top, int step, int floor_v);
      int v;
      v = top - p * step;
      return (v < floor_v) ? floor_v : v;
   endfunction

endpackage

// File: rtl/psq_op_table.sv
module psq_op_table
   import psq_pkg::*;
#(
   parameter int NUM_PS     = 8,
   parameter int PS_W       = 3,
   parameter int RATIO_W    = 8,
   parameter int VID_W      = 8,
   parameter int RATIO_TOP  = 35,
   parameter int RATIO_STEP = 3,
   parameter int VID_TOP    = 200,
   parameter int VID_STEP   = 10,
   parameter int VID_FLOOR  = 140
) (
   input  logic [PS_W-1:0]    idx,
   output logic [RATIO_W-1:0] ratio,
   output logic [VID_W-1:0]   vid
);

   logic [RATIO_W-1:0] ratio_tab [NUM_PS];
   logic [VID_W-1:0]   vid_tab   [NUM_PS];

   for (genvar g = 0; g < NUM_PS; g++) begin : g_ent
      localparam int RV = psq_ratio_of(g, RATIO_TOP, RATIO_STEP);
      localparam int VV = psq_vid_of(g, VID_TOP, VID_STEP, VID_FLOOR);
      assign ratio_tab[g] = RATIO_W'(RV);
      assign vid_tab[g]   = VID_W'(VV);
   end

   if (psq_ratio_of(NUM_PS - 1, RATIO_TOP, RATIO_STEP) < 1) begin : g_bad_ratio
      $error("psq_op_table: slowest state would have a ratio below 1");
   end
   if (RATIO_TOP >= (1 << RATIO_W) || VID_TOP >= (1 << VID_W)) begin : g_bad_width
      $error("psq_op_table: top ratio or voltage code does not fit");
   end
   if (VID_FLOOR > VID_TOP || VID_FLOOR < 0) begin : g_bad_floor
      $error("psq_op_table: voltage floor outside range");
   end

   assign ratio = ratio_tab[idx];
   assign vid   = vid_tab[idx];

endmodule

// File: rtl/psq_req_capture.sv
module psq_req_capture
   import psq_pkg::*;
#(
   parameter int NUM_PS    = 8,
   parameter int PS_W      = 3,
   parameter bit CLAMP_OOR = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             core_active,
   input  logic             ctrl_we,
   input  logic [CSR_W-1:0] ctrl_wdata,
   input  logic             take,
   output logic [CSR_W-1:0] ctrl_q,
   output logic             pend_vld,
   output logic [PS_W-1:0]  pend_ps
);

   localparam logic [7:0]      LAST_FIELD = 8'(NUM_PS - 1);
   localparam logic [PS_W-1:0] LAST_PS    = PS_W'(NUM_PS - 1);

   logic            wr_ok;
   logic            in_range;
   logic            accept;
   logic [PS_W-1:0] ps_in;

   assign wr_ok    = ctrl_we && core_active;
   assign in_range = (ctrl_wdata[7:0] <= LAST_FIELD);

   if (CLAMP_OOR) begin : g_clamp
      assign accept = wr_ok;
      assign ps_in  = in_range ? ctrl_wdata[PS_W-1:0] : LAST_PS;
   end else begin : g_drop
      assign accept = wr_ok && in_range;
      assign ps_in  = ctrl_wdata[PS_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         pend_vld <= 1'b0;
         pend_ps  <= '0;
      end else if (accept) begin
         ctrl_q   <= ctrl_wdata;
         pend_vld <= 1'b1;
         pend_ps  <= ps_in;
      end else if (take) begin
         pend_vld <= 1'b0;
      end
   end

   AST_IDLE_CORE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_we && !core_active) |=> $stable(ctrl_q)); // R2
   AST_PEND_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      pend_vld |-> (pend_ps <= LAST_PS)); // R3
   AST_LATEST_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && in_range) |=> (pend_vld && pend_ps == $past(ctrl_wdata[PS_W-1:0]))); // R8

endmodule

// File: rtl/psq_step_engine.sv
module psq_step_engine
   import psq_pkg::*;
#(
   parameter int PS_W      = 3,
   parameter int RATIO_W   = 8,
   parameter int VID_W     = 8,
   parameter int RESET_PS  = 7,
   parameter int RST_RATIO = 14,
   parameter int RST_VID   = 140
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pend_vld,
   input  logic [PS_W-1:0]    pend_ps,
   input  logic [RATIO_W-1:0] lk_ratio,
   input  logic [VID_W-1:0]   lk_vid,
   input  logic               vr_ack,
   input  logic               pll_lock,
   output logic [PS_W-1:0]    lk_ps,
   output logic               take,
   output logic               vr_req,
   output logic [VID_W-1:0]   vr_vid,
   output logic               pll_req,
   output logic [RATIO_W-1:0] pll_ratio,
   output logic [PS_W-1:0]    cur_ps
);

   sq_state_e       state;
   logic [PS_W-1:0] tgt_ps;

   assign lk_ps = (state == SQ_IDLE) ? pend_ps : tgt_ps;
   assign take  = (state == SQ_IDLE) && pend_vld;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= SQ_IDLE;
         cur_ps    <= PS_W'(RESET_PS);
         tgt_ps    <= PS_W'(RESET_PS);
         vr_req    <= 1'b0;
         vr_vid    <= VID_W'(RST_VID);
         pll_req   <= 1'b0;
         pll_ratio <= RATIO_W'(RST_RATIO);
      end else begin
         case (state)
            SQ_IDLE: begin
               if (pend_vld) begin
                  tgt_ps <= pend_ps;
                  if (pend_ps < cur_ps) begin
                     state  <= SQ_V_FIRST;
                     vr_req <= 1'b1;
                     vr_vid <= lk_vid;
                  end else if (pend_ps > cur_ps) begin
                     state     <= SQ_F_FIRST;
                     pll_req   <= 1'b1;
                     pll_ratio <= lk_ratio;
                  end
               end
            end
            SQ_V_FIRST: begin
               if (vr_ack) begin
                  vr_req    <= 1'b0;
                  pll_req   <= 1'b1;
                  pll_ratio <= lk_ratio;
                  state     <= SQ_F_SECOND;
               end
            end
            SQ_F_SECOND: begin
               if (pll_lock) begin
                  pll_req <= 1'b0;
                  cur_ps  <= tgt_ps;
                  state   <= SQ_IDLE;
               end
            end
            SQ_F_FIRST: begin
               if (pll_lock) begin
                  pll_req <= 1'b0;
                  vr_req  <= 1'b1;
                  vr_vid  <= lk_vid;
                  state   <= SQ_V_SECOND;
               end
            end
            SQ_V_SECOND: begin
               if (vr_ack) begin
                  vr_req <= 1'b0;
                  cur_ps <= tgt_ps;
                  state  <= SQ_IDLE;
               end
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end

   AST_VR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (vr_req && !vr_ack) |=> (vr_req && $stable(vr_vid))); // R10
   AST_PLL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (pll_req && !pll_lock) |=> (pll_req && $stable(pll_ratio))); // R10
   AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !(vr_req && pll_req)); // R5
   AST_RAISE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pll_req) && tgt_ps < cur_ps) |-> $past(vr_ack)); // R5
   AST_LOWER_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(vr_req) && tgt_ps > cur_ps) |-> $past(pll_lock)); // R6
   AST_COMMIT_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cur_ps) |-> $past(vr_ack || pll_lock)); // R7
   AST_SAME_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SQ_IDLE && pend_vld && pend_ps == cur_ps) |=> (!vr_req && !pll_req)); // R9

endmodule

// File: rtl/perf_state_sequencer.sv
module perf_state_sequencer
   import psq_pkg::*;
#(
   parameter int NUM_PS     = 8,
   parameter int RATIO_W    = 8,
   parameter int VID_W      = 8,
   parameter int RATIO_TOP  = 35,
   parameter int RATIO_STEP = 3,
   parameter int VID_TOP    = 200,
   parameter int VID_STEP   = 10,
   parameter int VID_FLOOR  = 140,
   parameter int RESET_PS   = NUM_PS - 1,
   parameter bit CLAMP_OOR  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               core_active,
   input  logic               ctrl_we,
   input  logic [15:0]        ctrl_wdata,
   output logic [15:0]        ctrl_rdata,
   output logic [15:0]        stat_rdata,
   output logic               vr_req,
   output logic [VID_W-1:0]   vr_vid,
   input  logic               vr_ack,
   output logic               pll_req,
   output logic [RATIO_W-1:0] pll_ratio,
   input  logic               pll_lock
);

   localparam int PS_W      = (NUM_PS > 1) ? $clog2(NUM_PS) : 1;
   localparam int RST_RATIO = psq_ratio_of(RESET_PS, RATIO_TOP, RATIO_STEP);
   localparam int RST_VID   = psq_vid_of(RESET_PS, VID_TOP, VID_STEP, VID_FLOOR);

   if (NUM_PS < 2 || NUM_PS > 256) begin : g_bad_count
      $error("perf_state_sequencer: state count must be 2..256");
   end
   if (RESET_PS < 0 || RESET_PS >= NUM_PS) begin : g_bad_reset
      $error("perf_state_sequencer: reset state out of range");
   end
   if (RATIO_W > 8) begin : g_bad_rw
      $error("perf_state_sequencer: ratio must fit the status byte");
   end

   logic [PS_W-1:0]    pend_ps;
   logic               pend_vld;
   logic               take;
   logic [PS_W-1:0]    lk_ps;
   logic [RATIO_W-1:0] lk_ratio;
   logic [VID_W-1:0]   lk_vid;
   logic [PS_W-1:0]    cur_ps;
   logic [RATIO_W-1:0] cur_ratio;
   logic [VID_W-1:0]   cur_vid_unused;

   psq_req_capture #(
      .NUM_PS(NUM_PS), .PS_W(PS_W), .CLAMP_OOR(CLAMP_OOR)
   ) i_capture (
      .clk(clk), .rst_n(rst_n), .core_active(core_active),
      .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .take(take),
      .ctrl_q(ctrl_rdata), .pend_vld(pend_vld), .pend_ps(pend_ps)
   );

   psq_op_table #(
      .NUM_PS(NUM_PS), .PS_W(PS_W), .RATIO_W(RATIO_W), .VID_W(VID_W),
      .RATIO_TOP(RATIO_TOP), .RATIO_STEP(RATIO_STEP),
      .VID_TOP(VID_TOP), .VID_STEP(VID_STEP), .VID_FLOOR(VID_FLOOR)
   ) i_tgt_table (
      .idx(lk_ps), .ratio(lk_ratio), .vid(lk_vid)
   );

   psq_op_table #(
      .NUM_PS(NUM_PS), .PS_W(PS_W), .RATIO_W(RATIO_W), .VID_W(VID_W),
      .RATIO_TOP(RATIO_TOP), .RATIO_STEP(RATIO_STEP),
      .VID_TOP(VID_TOP), .VID_STEP(VID_STEP), .VID_FLOOR(VID_FLOOR)
   ) i_cur_table (
      .idx(cur_ps), .ratio(cur_ratio), .vid(cur_vid_unused)
   );

   psq_step_engine #(
      .PS_W(PS_W), .RATIO_W(RATIO_W), .VID_W(VID_W),
      .RESET_PS(RESET_PS), .RST_RATIO(RST_RATIO), .RST_VID(RST_VID)
   ) i_engine (
      .clk(clk), .rst_n(rst_n), .pend_vld(pend_vld), .pend_ps(pend_ps),
      .lk_ratio(lk_ratio), .lk_vid(lk_vid), .vr_ack(vr_ack), .pll_lock(pll_lock),
      .lk_ps(lk_ps), .take(take), .vr_req(vr_req), .vr_vid(vr_vid),
      .pll_req(pll_req), .pll_ratio(pll_ratio), .cur_ps(cur_ps)
   );

   assign stat_rdata = {8'(cur_ratio), 8'(cur_ps)};

   AST_STATUS_MATCHES_PLL: assert property (@(posedge clk) disable iff (!rst_n)
      (!vr_req && !pll_req && !pend_vld) |-> (stat_rdata[15:8] == 8'(pll_ratio))); // R7

endmodule

// File: tb/test_perf_state_sequencer.sv
module test_perf_state_sequencer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        core_active = 1'b0;
   logic        ctrl_we = 1'b0;
   logic [15:0] ctrl_wdata = '0;
   logic [15:0] ctrl_rdata, stat_rdata;
   logic        vr_req, pll_req;
   logic [7:0]  vr_vid, pll_ratio;
   logic        vr_ack = 1'b0;
   logic        pll_lock = 1'b0;

   always #4 clk = ~clk;

   perf_state_sequencer i_perf_state_sequencer (
      .clk(clk), .rst_n(rst_n), .core_active(core_active),
      .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
      .stat_rdata(stat_rdata), .vr_req(vr_req), .vr_vid(vr_vid), .vr_ack(vr_ack),
      .pll_req(pll_req), .pll_ratio(pll_ratio), .pll_lock(pll_lock)
   );

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit done   = 1'b0;

   function automatic int f_ratio(int p);
      return 35 - 3 * p;
   endfunction
   function automatic int f_vid(int p);
      int v;
      v = 200 - 10 * p;
      return (v < 140) ? 140 : v;
   endfunction
   function automatic int f_clamp(int field);
      return (field > 7) ? 7 : field;
   endfunction

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // behavioural reference model, advanced on each rising edge
   int m_state, m_cur, m_tgt, m_pend, m_pvld, m_vreq, m_vid, m_preq, m_ratio, m_ctrl;
   always @(posedge clk) begin
      if (!rst_n) begin
         m_state = 0; m_cur = 7; m_tgt = 7; m_pend = 0; m_pvld = 0;
         m_vreq = 0; m_vid = f_vid(7); m_preq = 0; m_ratio = f_ratio(7); m_ctrl = 0;
      end else begin
         case (m_state)
            0: if (m_pvld != 0) begin
                  m_pvld = 0;
                  m_tgt  = m_pend;
                  if (m_pend < m_cur) begin
                     m_state = 1; m_vreq = 1; m_vid = f_vid(m_pend);
                  end else if (m_pend > m_cur) begin
                     m_state = 3; m_preq = 1; m_ratio = f_ratio(m_pend);
                  end
               end
            1: if (vr_ack) begin
                  m_vreq = 0; m_preq = 1; m_ratio = f_ratio(m_tgt); m_state = 2;
               end
            2: if (pll_lock) begin
                  m_preq = 0; m_cur = m_tgt; m_state = 0;
               end
            3: if (pll_lock) begin
                  m_preq = 0; m_vreq = 1; m_vid = f_vid(m_tgt); m_state = 4;
               end
            4: if (vr_ack) begin
                  m_vreq = 0; m_cur = m_tgt; m_state = 0;
               end
            default: m_state = 0;
         endcase
         if (ctrl_we && core_active) begin
            m_ctrl = int'(ctrl_wdata);
            m_pend = f_clamp(int'(ctrl_wdata[7:0]));
            m_pvld = 1;
         end
      end
   end

   // per-cycle compare, monitors and regulator/PLL models on the falling edge
   int  v_dly = 2, p_dly = 3, vcnt = 0, pcnt = 0;
   int  rises_v = 0, rises_p = 0, first_rise = 0, run_v = 0, max_run_v = 0;
   logic prev_v = 1'b0, prev_p = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         check("R5/R6 vr_req", int'(vr_req), m_vreq);
         check("R4 vr_vid", int'(vr_vid), m_vid);
         check("R5/R6 pll_req", int'(pll_req), m_preq);
         check("R4 pll_ratio", int'(pll_ratio), m_ratio);
         check("R7 stat_rdata", int'(stat_rdata), (f_ratio(m_cur) << 8) | m_cur);
         check("R2 ctrl_rdata", int'(ctrl_rdata), m_ctrl);
         if (vr_req && !prev_v) begin
            rises_v++;
            if (first_rise == 0) first_rise = 1;
         end
         if (pll_req && !prev_p) begin
            rises_p++;
            if (first_rise == 0) first_rise = 2;
         end
         run_v = vr_req ? run_v + 1 : 0;
         if (run_v > max_run_v) max_run_v = run_v;
         prev_v = vr_req;
         prev_p = pll_req;
      end
      if (vr_ack) vr_ack = 1'b0;
      else if (vr_req) begin
         if (vcnt >= v_dly) begin vr_ack = 1'b1; vcnt = 0; end
         else vcnt++;
      end else vcnt = 0;
      if (pll_lock) pll_lock = 1'b0;
      else if (pll_req) begin
         if (pcnt >= p_dly) begin pll_lock = 1'b1; pcnt = 0; end
         else pcnt++;
      end else pcnt = 0;
   end

   task automatic report();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         done = 1'b1;
         checks++; fails++;
         $display("FAIL watchdog actual=%0d expected=<20000", cycles);
         report();
      end
   end

   task automatic wr(logic [15:0] val);
      @(negedge clk);
      ctrl_we = 1'b1; ctrl_wdata = val;
      @(negedge clk);
      ctrl_we = 1'b0;
   endtask

   task automatic clear_mon();
      rises_v = 0; rises_p = 0; first_rise = 0; max_run_v = 0;
   endtask

   task automatic wait_idle();
      repeat (3) @(negedge clk);
      for (int i = 0; i < 500; i++) begin
         if (!vr_req && !pll_req && m_state == 0 && m_pvld == 0) break;
         @(negedge clk);
      end
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset point
      check("R1 stat", int'(stat_rdata), (14 << 8) | 7);
      check("R1 vr_vid", int'(vr_vid), 140);
      check("R1 pll_ratio", int'(pll_ratio), 14);
      check("R1 reqs", int'({vr_req, pll_req}), 0);
      check("R1 ctrl", int'(ctrl_rdata), 0);
      core_active = 1'b1;

      // R5 raise 7 -> 3, voltage first; R10 first request two edges after write
      clear_mon();
      @(negedge clk);
      ctrl_we = 1'b1; ctrl_wdata = 16'h0003;
      @(negedge clk);
      ctrl_we = 1'b0;
      check("R10 no req yet", int'(vr_req), 0);
      @(negedge clk);
      check("R10 vr_req after two edges", int'(vr_req), 1);
      wait_idle();
      check("R5 voltage step first", first_rise, 1);
      check("R4 state3 stat", int'(stat_rdata), (26 << 8) | 3);
      check("R4 state3 vid", int'(vr_vid), 170);

      // R6 lower 3 -> 6, PLL first, voltage floor
      clear_mon();
      wr(16'h0006);
      wait_idle();
      check("R6 pll step first", first_rise, 2);
      check("R6 state6 stat", int'(stat_rdata), (17 << 8) | 6);
      check("R4 state6 vid", int'(vr_vid), 140);

      // R2 write while core idle is ignored
      clear_mon();
      core_active = 1'b0;
      wr(16'h0001);
      repeat (10) @(negedge clk);
      check("R2 ctrl unchanged", int'(ctrl_rdata), 16'h0006);
      check("R2 no requests", rises_v + rises_p, 0);
      check("R2 stat unchanged", int'(stat_rdata), (17 << 8) | 6);
      core_active = 1'b1;

      // R3 out-of-range field clamps to the slowest state
      wr(16'hAB09);
      wait_idle();
      check("R3 clamp stat", int'(stat_rdata), (14 << 8) | 7);
      check("R3 full word kept", int'(ctrl_rdata), 16'hAB09);

      // R9 same state: no handshake
      clear_mon();
      wr(16'h0007);
      repeat (10) @(negedge clk);
      check("R9 no requests", rises_v + rises_p, 0);

      // R8 latest pending wins; R7 status holds mid-transition; R10 hold
      clear_mon();
      v_dly = 8; p_dly = 8;
      wr(16'h0002);
      repeat (3) @(negedge clk);
      check("R7 stat during transition", int'(stat_rdata), (14 << 8) | 7);
      wr(16'h0005);
      wr(16'h0000);
      wait_idle();
      check("R8 final stat", int'(stat_rdata), (35 << 8) | 0);
      check("R8 two transitions", rises_p, 2);
      check("R4 state0 vid", int'(vr_vid), 200);
      check("R10 vr_req held", int'(max_run_v >= 8), 1);

      // R6 lower 0 -> 4 with short delays
      clear_mon();
      v_dly = 0; p_dly = 1;
      wr(16'h0004);
      wait_idle();
      check("R6 pll first again", first_rise, 2);
      check("R6 state4 stat", int'(stat_rdata), (23 << 8) | 4);
      check("R4 state4 vid", int'(vr_vid), 160);

      done = 1'b1;
      report();
   end

endmodule